// File: doc/BRIEF.md
# Radix-2^3 Delay-Feedback FFT Stage

This block is one pipeline stage of a streaming fixed-point FFT that splits the transform by decimation in frequency. It takes one complex sample per enabled clock, in natural time order, and passes the stream through three radix-2 butterflies. Each butterfly keeps its own feedback buffer, of depth N/2, N/4 and N/8. Between the butterflies it applies the rotations by -j and by e^(-jπ/4). These are built from swaps, negations, shifts and adds, so the stage needs no general multiplier. For N = 8 the stage computes a complete 8-point DFT. For larger N it produces the partially transformed stream, and a non-constant twiddle multiplier placed after it finishes the job. For that multiplier, the stage presents with every output sample the index pair it needs.

A single counter in a shared controller drives the whole stage. From that counter the controller derives each buffer's address, each butterfly's fill or combine mode, both rotation selects and the twiddle index outputs. Every input is sign-extended, and each butterfly and each rotation point adds one bit, so nothing can overflow. The output is W+5 bits wide. The `in_en` input stalls the stage: when it is low, no state changes.

Top module: `sdf8_stage`

## Requirements
- R1: While `rst_n` is low, and after it goes low in the middle of a stream, `out_valid` is 0, `out_re` and `out_im` are 0, and `tw_k` and `tw_n4` are 0.
- R2: Sample s is the s-th enabled input after reset, counting from 0. `out_valid` first goes high after the clock edge that accepts sample 7N/8, and not before. The output at that edge is index 0 of frame 0.
- R3: Output sample q of a frame (q = 0..N-1) carries the transform result whose frequency index has k1 = q[log2N-1], k2 = q[log2N-2] and k3 = q[log2N-3]. For N = 8, output q equals X[k1 + 2·k2 + 4·k3] of the 8-point DFT X[k] = Σ x[n]·e^(-j2πkn/8). Frames follow each other with no gap.
- R4: `tw_k` carries k1 + 2·k2 + 4·k3 of the current output. Across a frame it steps through 0, 4, 2, 6, 1, 5, 3, 7, and each value is held for N/8 outputs. `tw_n4` counts 0 to N/8-1 within each group and is 0 when N = 8.
- R5: The -j rotations are exact: the real and imaginary parts are swapped and the new imaginary part is negated. For N = 8, an input that is non-zero only at even sample indices gives outputs exactly equal to the DFT.
- R6: The e^(-jπ/4) rotation multiplies by 45/64 using only shifts and adds, then truncates (floor) back to the stage width. For N = 8, any input gives outputs within 4 + (Σ|x_re| + |x_im|)/100 LSB of the exact DFT, on both parts.
- R7: While `in_en` is low, the counter, the buffers and the output registers hold their values. `out_valid` is 0 after such an edge. A stream with stall cycles inserted gives the same results as one without them.
- R8: Full-scale inputs do not overflow. Every sample at +2^(W-1)-1 real and -2^(W-1) imaginary gives exactly N times those values at frequency 0, and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_en | input | 1 | Sample accept; when low the stage holds |
| in_re | input | W | Input real part, two's complement |
| in_im | input | W | Input imaginary part, two's complement |
| out_valid | output | 1 | Output sample is a real result |
| out_re | output | W+5 | Output real part |
| out_im | output | W+5 | Output imaginary part |
| tw_n4 | output | max(log2N-3,1) | Low index n4 for the following twiddle |
| tw_k | output | 3 | k1 + 2·k2 + 4·k3 for the following twiddle |

## Verification
The bench runs an 8-point configuration, so the stage by itself is a full DFT that can be checked against a reference computed with real arithmetic. Some patterns touch only the swap-and-negate path: an impulse at time zero, a constant, and energy only at even samples. On these the outputs must be exact, which separates a broken rotation from rounding noise. Patterns with odd-index energy go through the shift-add constant and are held to a tolerance that grows with input energy. A full-scale frame exposes missing width growth. A burst of stall cycles in the middle of a frame and a reset in the middle of a stream check the hold and restart behaviour, including the exact cycle of the first valid output.

// File: rtl/sdf8_pkg.sv
package sdf8_pkg;
  // Butterfly phase: store incoming samples, or combine with the stored half.
  typedef enum logic {BF_FILL = 1'b0, BF_CALC = 1'b1} bf_mode_e;
endpackage

// File: rtl/sdf8_ctrl.sv
module sdf8_ctrl
  import sdf8_pkg::*;
#(
  parameter  int N   = 64,
  localparam int LG  = $clog2(N),
  localparam int N4W = (LG > 3) ? LG - 3 : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  output bf_mode_e       mode1,
  output bf_mode_e       mode2,
  output bf_mode_e       mode3,
  output logic [LG-2:0]  addr1,
  output logic [LG-3:0]  addr2,
  output logic [N4W-1:0] addr3,
  output logic           rot1_on,
  output logic           rot2_on,
  output logic [1:0]     rot2_sel,
  output logic [2:0]     tw_k,
  output logic [N4W-1:0] tw_n4,
  output logic           primed
);
  localparam logic [LG-1:0] LAST_FILL = LG'(7 * N / 8 - 1);
  localparam logic [LG-1:0] FIRST_OUT = LG'(7 * N / 8);

  logic [LG-1:0] cnt, idx2, idx3, idxq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      primed <= 1'b0;
    end else if (en) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST_FILL) primed <= 1'b1;
    end
  end

  // Index seen by each butterfly: the input counter minus upstream latency.
  assign idx2 = cnt - LG'(N / 2);
  assign idx3 = cnt - LG'(3 * N / 4);
  assign idxq = cnt - LG'(7 * N / 8);

  assign mode1    = bf_mode_e'(cnt[LG-1]);
  assign addr1    = cnt[LG-2:0];
  assign mode2    = bf_mode_e'(idx2[LG-2]);
  assign addr2    = idx2[LG-3:0];
  assign rot1_on  = idx2[LG-1] & idx2[LG-2];
  assign mode3    = bf_mode_e'(idx3[LG-3]);
  assign rot2_on  = idx3[LG-3];
  assign rot2_sel = {idx3[LG-2], idx3[LG-1]};
  assign tw_k     = {idxq[LG-3], idxq[LG-2], idxq[LG-1]};

  generate
    if (LG > 3) begin : g_low
      assign addr3 = idx3[LG-4:0];
      assign tw_n4 = idxq[LG-4:0];
    end else begin : g_none
      assign addr3 = '0;
      assign tw_n4 = '0;
    end
  endgenerate

  AST_STALL_CNT: assert property (@(posedge clk) disable iff (!rst_n) !en |=> $stable(cnt)) else $error("counter moved during stall"); // R7
  AST_FIRST_VALID: assert property (@(posedge clk) disable iff (!rst_n) $rose(primed) |-> cnt == FIRST_OUT) else $error("pipeline primed at wrong count"); // R2
endmodule

// File: rtl/sdf8_bfly.sv
module sdf8_bfly
  import sdf8_pkg::*;
#(
  parameter  int IW    = 16,
  parameter  int DEPTH = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                en,
  input  bf_mode_e            mode,
  input  logic [AW-1:0]       addr,
  input  logic signed [IW-1:0] x_re,
  input  logic signed [IW-1:0] x_im,
  output logic signed [IW:0]   y_re,
  output logic signed [IW:0]   y_im
);
  logic signed [IW:0] buf_re [2**AW];
  logic signed [IW:0] buf_im [2**AW];
  logic signed [IW:0] fb_re, fb_im, xe_re, xe_im, wr_re, wr_im;

  assign fb_re = buf_re[addr];
  assign fb_im = buf_im[addr];
  assign xe_re = x_re;
  assign xe_im = x_im;

  always_comb begin
    if (mode == BF_CALC) begin
      y_re  = fb_re + xe_re;
      y_im  = fb_im + xe_im;
      wr_re = fb_re - xe_re;
      wr_im = fb_im - xe_im;
    end else begin
      y_re  = fb_re;
      y_im  = fb_im;
      wr_re = xe_re;
      wr_im = xe_im;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      buf_re[addr] <= wr_re;
      buf_im[addr] <= wr_im;
    end
  end
endmodule

// File: rtl/sdf8_stage.sv
module sdf8_stage
  import sdf8_pkg::*;
#(
  parameter  int N   = 64,
  parameter  int W   = 16,
  localparam int LG  = $clog2(N),
  localparam int N4W = (LG > 3) ? LG - 3 : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_en,
  input  logic signed [W-1:0] in_re,
  input  logic signed [W-1:0] in_im,
  output logic                out_valid,
  output logic signed [W+4:0] out_re,
  output logic signed [W+4:0] out_im,
  output logic [N4W-1:0]      tw_n4,
  output logic [2:0]          tw_k
);
  // Constant sqrt(2)/2 ~ 45/64 = 2^-1 + 2^-3 + 2^-4 + 2^-6, floor after the sum.
  function automatic logic signed [W+3:0] scale45(input logic signed [W+3:0] v);
    logic signed [W+9:0] p;
    p = {{6{v[W+3]}}, v};
    p = (p <<< 5) + (p <<< 3) + (p <<< 2) + p;
    return p[W+9:6];
  endfunction

  bf_mode_e m1, m2, m3;
  logic [LG-2:0]  a1;
  logic [LG-3:0]  a2;
  logic [N4W-1:0] a3, c_n4;
  logic           rot1_on, rot2_on, primed;
  logic [1:0]     rot2_sel;
  logic [2:0]     c_k;

  logic signed [W:0]   y1_re, y1_im;
  logic signed [W+1:0] r1_re, r1_im;
  logic signed [W+2:0] y2_re, y2_im;
  logic signed [W+3:0] r2_re, r2_im, s_ab, d_ba;
  logic signed [W+4:0] y3_re, y3_im;

  sdf8_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(in_en),
    .mode1(m1), .mode2(m2), .mode3(m3),
    .addr1(a1), .addr2(a2), .addr3(a3),
    .rot1_on(rot1_on), .rot2_on(rot2_on), .rot2_sel(rot2_sel),
    .tw_k(c_k), .tw_n4(c_n4), .primed(primed)
  );

  sdf8_bfly #(.IW(W), .DEPTH(N / 2)) u_bf1 (
    .clk(clk), .en(in_en), .mode(m1), .addr(a1),
    .x_re(in_re), .x_im(in_im), .y_re(y1_re), .y_im(y1_im)
  );

  // -j on the odd half of the difference branch: swap, negate new imaginary.
  always_comb begin
    if (rot1_on) begin
      r1_re = y1_im;
      r1_im = -$signed({y1_re[W], y1_re});
    end else begin
      r1_re = y1_re;
      r1_im = y1_im;
    end
  end

  sdf8_bfly #(.IW(W + 2), .DEPTH(N / 4)) u_bf2 (
    .clk(clk), .en(in_en), .mode(m2), .addr(a2),
    .x_re(r1_re), .x_im(r1_im), .y_re(y2_re), .y_im(y2_im)
  );

  // W8^(k1 + 2*k2) for the odd third-level index; sel = {k2, k1}.
  assign s_ab = {y2_re[W+2], y2_re} + {y2_im[W+2], y2_im};
  assign d_ba = {y2_im[W+2], y2_im} - {y2_re[W+2], y2_re};

  always_comb begin
    r2_re = y2_re;
    r2_im = y2_im;
    if (rot2_on) begin
      case (rot2_sel)
        2'b01: begin r2_re = scale45(s_ab); r2_im = scale45(d_ba); end
        2'b10: begin r2_re = y2_im; r2_im = -$signed({y2_re[W+2], y2_re}); end
        2'b11: begin r2_re = scale45(d_ba); r2_im = -scale45(s_ab); end
        default: ;
      endcase
    end
  end

  sdf8_bfly #(.IW(W + 4), .DEPTH(N / 8)) u_bf3 (
    .clk(clk), .en(in_en), .mode(m3), .addr(a3),
    .x_re(r2_re), .x_im(r2_im), .y_re(y3_re), .y_im(y3_im)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
      tw_k      <= '0;
      tw_n4     <= '0;
    end else begin
      out_valid <= in_en & primed;
      if (in_en) begin
        out_re <= y3_re;
        out_im <= y3_im;
        tw_k   <= c_k;
        tw_n4  <= c_n4;
      end
    end
  end

  AST_STALL_OUT: assert property (@(posedge clk) disable iff (!rst_n) !in_en |=> !out_valid && $stable(out_re) && $stable(out_im)) else $error("output moved during stall"); // R7
  AST_K_HOLD: assert property (@(posedge clk) disable iff (!rst_n) out_valid && $past(out_valid) && tw_n4 != '0 |-> tw_k == $past(tw_k)) else $error("k index changed inside a group"); // R4
endmodule

// File: tb/sdf8_stage_tb.sv
`timescale 1ns/1ps
module sdf8_stage_tb;
  localparam int N  = 8;
  localparam int W  = 12;
  localparam int NF = 7;
  localparam logic [NF-1:0] EXACT = 7'b0010111;

  localparam logic signed [W-1:0] STIM_RE [NF*N] = '{
    300, 0, 0, 0, 0, 0, 0, 0,
    100, 100, 100, 100, 100, 100, 100, 100,
    0, 0, 200, 0, 0, 0, -75, 0,
    0, 256, 0, 0, 0, 0, 0, 0,
    2047, 2047, 2047, 2047, 2047, 2047, 2047, 2047,
    0, 37, 74, 111, 148, 185, 222, 259,
    500, -300, 120, -7, 900, -1000, 45, 333};
  localparam logic signed [W-1:0] STIM_IM [NF*N] = '{
    0, 0, 0, 0, 0, 0, 0, 0,
    -50, -50, -50, -50, -50, -50, -50, -50,
    40, 0, 0, 0, 0, 0, 0, 0,
    0, 0, 0, -90, 0, 0, 0, 0,
    -2048, -2048, -2048, -2048, -2048, -2048, -2048, -2048,
    0, -11, -22, -33, -44, -55, -66, -77,
    -250, 60, 700, -800, 10, -2048, 2047, 5};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_en = 1'b0;
  logic signed [W-1:0] in_re = '0, in_im = '0;
  logic out_valid;
  logic signed [W+4:0] out_re, out_im;
  logic [0:0] tw_n4;
  logic [2:0] tw_k;

  int checks = 0, errors = 0, nvalid = 0, accepted = 0;
  bit mon = 1'b0, last_en = 1'b0, done = 1'b0;
  logic signed [W+4:0] hold_re = '0, hold_im = '0;

  always #2.5 clk = ~clk;

  sdf8_stage #(.N(N), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_en(in_en), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
    .tw_n4(tw_n4), .tw_k(tw_k));

  task automatic check(input bit ok, input string req, input string what, input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0f expected %0f", req, what, act, exp);
    end
  endtask

  function automatic real ref_part(input int f, input int k, input bit imag);
    real acc = 0.0;
    for (int n = 0; n < N; n++) begin
      real ang = -2.0 * 3.14159265358979 * k * n / N;
      real xr = real'(STIM_RE[f*N+n]);
      real xi = real'(STIM_IM[f*N+n]);
      acc += imag ? (xr * $sin(ang) + xi * $cos(ang)) : (xr * $cos(ang) - xi * $sin(ang));
    end
    return acc;
  endfunction

  function automatic real energy(input int f);
    real s = 0.0;
    for (int n = 0; n < N; n++) begin
      s += (STIM_RE[f*N+n] < 0 ? -real'(STIM_RE[f*N+n]) : real'(STIM_RE[f*N+n]));
      s += (STIM_IM[f*N+n] < 0 ? -real'(STIM_IM[f*N+n]) : real'(STIM_IM[f*N+n]));
    end
    return s;
  endfunction

  task automatic observe();
    if (!mon) return;
    if (!last_en) begin
      check(!out_valid && out_re == hold_re && out_im == hold_im, "R7", "stall hold",
            real'(out_re), real'(hold_re));
    end
    if (out_valid) begin
      int f = nvalid / N;
      int q = nvalid % N;
      int k = {q[0], q[1], q[2]};
      if (nvalid == 0) check(accepted == 7 * N / 8 + 1, "R2", "first valid sample count", accepted, 7 * N / 8 + 1);
      if (f < NF) begin
        real er = ref_part(f, k, 1'b0);
        real ei = ref_part(f, k, 1'b1);
        real dr = real'(out_re) - er;
        real di = real'(out_im) - ei;
        real tol = EXACT[f] ? 0.5 : 4.0 + energy(f) / 100.0;
        string req = (f == 4) ? "R8" : (EXACT[f] ? "R5" : "R6");
        if (dr < 0) dr = -dr;
        if (di < 0) di = -di;
        check(dr <= tol, req, $sformatf("R3 frame %0d X[%0d] re", f, k), real'(out_re), er);
        check(di <= tol, req, $sformatf("R3 frame %0d X[%0d] im", f, k), real'(out_im), ei);
        check(tw_k == 3'(k), "R4", $sformatf("tw_k at q=%0d", q), real'(tw_k), real'(k));
        check(tw_n4 == 1'b0, "R4", "tw_n4 zero for N=8", real'(tw_n4), 0.0);
      end
      nvalid++;
    end
    hold_re = out_re;
    hold_im = out_im;
  endtask

  task automatic drive(input bit e, input logic signed [W-1:0] re, input logic signed [W-1:0] im);
    @(negedge clk);
    observe();
    in_en = e;
    in_re = re;
    in_im = im;
    if (e) accepted++;
    last_en = e;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && out_re == 0 && out_im == 0 && tw_k == 0 && tw_n4 == 0, "R1", "reset state",
          real'(out_valid), 0.0);
    rst_n = 1'b1;
    mon = 1'b1;
    // Vector table: frames back to back, one stall burst inside frame 5.
    for (int f = 0; f < NF; f++) begin
      for (int n = 0; n < N; n++) begin
        if (f == 5 && n == 3) repeat (3) drive(1'b0, STIM_RE[f*N+n], STIM_IM[f*N+n]);
        drive(1'b1, STIM_RE[f*N+n], STIM_IM[f*N+n]);
      end
    end
    for (int n = 0; n < N; n++) drive(1'b1, '0, '0);
    drive(1'b0, '0, '0);
    mon = 1'b0;
    check(nvalid == NF * N + 1, "R3", "back-to-back output count", nvalid, NF * N + 1);

    // Reset in the middle of a stream.
    for (int n = 0; n < 5; n++) drive(1'b1, 12'sd77, -12'sd9);
    @(negedge clk);
    rst_n = 1'b0;
    in_en = 1'b0;
    @(negedge clk);
    check(!out_valid && out_re == 0 && out_im == 0 && tw_k == 0, "R1", "mid-stream reset",
          real'(out_re), 0.0);
    rst_n = 1'b1;
    accepted = 0;
    for (int n = 0; n < 7 * N / 8; n++) drive(1'b1, '0, '0);
    @(negedge clk);
    check(!out_valid, "R2", "no valid before 7N/8+1 samples", real'(out_valid), 0.0);
    in_en = 1'b1;
    @(negedge clk);
    in_en = 1'b0;
    check(out_valid && tw_k == 0, "R2", "valid after sample 7N/8", real'(out_valid), 1.0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule